// File: doc/BRIEF.md
# Delay-Based Packet Drop Controller

This block decides, packet by packet, whether one egress queue should forward or discard the packet now leaving it. It follows the controlled-delay scheme. A packet whose queueing delay stays under a target, or that leaves a nearly empty queue, is always forwarded. When the delay stays high, the controller enters a dropping phase. In that phase it discards packets at times that come closer together: the gap after each discard is the control interval divided by the square root of the number of discards so far.

The surrounding pipeline presents each packet as a one-cycle strobe. With the strobe come the measured queueing delay, the queue occupancy in bytes and a free-running microsecond timestamp. One cycle later the block returns a verdict. Its state is held in registers between packets: the phase flag, the discard count, the count kept from the previous phase, and the time of the next scheduled discard. Any state written for one packet is visible to a packet strobed in the very next cycle. The spacing values come from a table that is built at elaboration time.

Top module: `codel_drop_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, all four state values are cleared and `verdict_valid` and `verdict_drop` are 0 afterwards.
- R2: A packet with `pkt_delay_us` < TARGET_US, or with `pkt_qbytes` < MTU_BYTES, is forwarded (`verdict_drop` = 0) and returns the controller to the non-dropping phase.
- R3: The first violating packet seen in the non-dropping phase moves the controller into the dropping phase and is forwarded. The next discard time is then set to `now_us` + INTERVAL_US.
- R4: In the dropping phase, a violating packet is discarded only if `now_us` has reached the next discard time. Each discard raises the count by one.
- R5: After a discard, the next discard time grows by floor(INTERVAL_US / sqrt(c)), where c is the new count. For counts of 256 and above, c is taken as 255; for count 0 the full interval is used.
- R6: On entry to the dropping phase, let d be the count minus the count kept from the previous phase. If d > 1 and `now_us` minus the old next discard time is less than 16 × INTERVAL_US, the count restarts at d; otherwise it restarts at 1. The kept count then takes the new count value.
- R7: Time is a 32-bit wrapping microsecond value. All time comparisons use the signed difference, so a discard time that lies past the wrap point is not reached early.
- R8: `verdict_valid` is high exactly one cycle after each `pkt_valid` strobe. A packet strobed in the next cycle sees the state written by the one before it.
- R9: The count saturates at 2^COUNT_W − 1 and never wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | One-cycle strobe per departing packet |
| pkt_delay_us | input | TIME_W | Measured queueing delay in microseconds |
| pkt_qbytes | input | QBYTE_W | Queue occupancy in bytes |
| now_us | input | TIME_W | Free-running wrapping timestamp in microseconds |
| verdict_valid | output | 1 | Verdict strobe, one cycle after `pkt_valid` |
| verdict_drop | output | 1 | 1 = discard the packet, 0 = forward it |

## Verification
The assertions check several rules on every cycle. The verdict follows its strobe by one cycle. A packet under target never gets a discard verdict and always clears the phase flag. Phase entry never discards. No discard happens before the scheduled time, and every discard raises the count by one with saturation. Other behaviour depends on the values that build up over a sequence of packets, and only the bench's directed scenarios show it. These are the exact spacing values, the choice between fast restart and restart at 1, discard times that lie past the timestamp wrap, and the spacing held steady once the count passes the table and saturates.

// File: rtl/codel_pkg.sv
// Shared constants and elaboration-time helpers for the drop controller.
// Assumes: the interval squared fits in 64 bits.
package codel_pkg;

    localparam int unsigned SPACING_DEPTH = 256;

    // Largest s with s*s*idx <= ival*ival, i.e. floor(ival / sqrt(idx)).
    function automatic longint unsigned spacing_of(longint unsigned ival, int unsigned idx);
        longint unsigned sq;
        longint unsigned s;
        longint unsigned t;
        sq = ival * ival;
        s  = 0;
        if (idx == 0) return ival;
        for (int b = 40; b >= 0; b--) begin
            t = s | (64'd1 << b);
            if (t <= ival) begin
                if (t * t * longint'(idx) <= sq) s = t;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/codel_spacing_rom.sv
// Spacing table: gives floor(INTERVAL / sqrt(count)) for a count.
// The table is filled at elaboration; counts past the last entry use it.
module codel_spacing_rom #(
    parameter int unsigned TIME_W      = 32,
    parameter int unsigned COUNT_W     = 16,
    parameter int unsigned INTERVAL_US = 100000
) (
    input  logic [COUNT_W-1:0] count,
    output logic [TIME_W-1:0]  spacing
);
    localparam int unsigned DEPTH = codel_pkg::SPACING_DEPTH;
    localparam int unsigned IDX_W = $clog2(DEPTH);

    logic [TIME_W-1:0] table_q [DEPTH];
    logic [IDX_W-1:0]  idx;

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        localparam longint unsigned VAL = codel_pkg::spacing_of(INTERVAL_US, i);
        assign table_q[i] = TIME_W'(VAL);
    end

    // Clamp the count to the last table entry.
    always_comb begin
        if (count > COUNT_W'(DEPTH - 1)) idx = IDX_W'(DEPTH - 1);
        else                             idx = count[IDX_W-1:0];
    end

    assign spacing = table_q[idx];
endmodule

// File: rtl/codel_decide.sv
// Per-packet decision logic: from the current state and one packet it works
// out the verdict and the next state. Purely combinational.
// Assumes the spacing input belongs to the count_bump output.
module codel_decide #(
    parameter int unsigned TIME_W      = 32,
    parameter int unsigned COUNT_W     = 16,
    parameter int unsigned QBYTE_W     = 24,
    parameter int unsigned TARGET_US   = 5000,
    parameter int unsigned INTERVAL_US = 100000,
    parameter int unsigned MTU_BYTES   = 1500
) (
    input  logic [TIME_W-1:0]  delay_us,
    input  logic [QBYTE_W-1:0] qbytes,
    input  logic [TIME_W-1:0]  now_us,
    input  logic               dropping,
    input  logic [COUNT_W-1:0] count,
    input  logic [COUNT_W-1:0] kept_count,
    input  logic [TIME_W-1:0]  next_time,
    input  logic [TIME_W-1:0]  spacing,
    output logic [COUNT_W-1:0] count_bump,
    output logic               drop,
    output logic               dropping_nx,
    output logic [COUNT_W-1:0] count_nx,
    output logic [COUNT_W-1:0] kept_nx,
    output logic [TIME_W-1:0]  next_nx
);
    localparam logic [COUNT_W-1:0] COUNT_MAX  = '1;
    localparam logic [TIME_W-1:0]  RESTART_WIN = TIME_W'(64'(INTERVAL_US) * 16);

    logic               violation;
    logic [TIME_W-1:0]  elapsed;
    logic               due;
    logic               recent;
    logic [COUNT_W-1:0] diff;

    // Compares times and counts, using signed time differences.
    always_comb begin
        violation  = (delay_us >= TIME_W'(TARGET_US)) && (qbytes >= QBYTE_W'(MTU_BYTES));
        elapsed    = now_us - next_time;
        due        = !elapsed[TIME_W-1];
        recent     = $signed(elapsed) < $signed(RESTART_WIN);
        diff       = count - kept_count;
        count_bump = (count == COUNT_MAX) ? COUNT_MAX : count + 1'b1;
    end

    // Picks the verdict and the next state.
    always_comb begin
        drop        = 1'b0;
        dropping_nx = dropping;
        count_nx    = count;
        kept_nx     = kept_count;
        next_nx     = next_time;
        if (!violation) begin
            dropping_nx = 1'b0;
        end else if (!dropping) begin
            dropping_nx = 1'b1;
            if (diff > COUNT_W'(1) && recent) count_nx = diff;
            else                              count_nx = COUNT_W'(1);
            kept_nx = count_nx;
            next_nx = now_us + TIME_W'(INTERVAL_US);
        end else if (due) begin
            drop     = 1'b1;
            count_nx = count_bump;
            next_nx  = next_time + spacing;
        end
    end
endmodule

// File: rtl/codel_drop_ctrl.sv
// Top of the drop controller: holds the state registers and the verdict.
// Each pkt_valid strobe updates the state at the same edge that registers the
// verdict, so a packet in the next cycle sees the new state.
module codel_drop_ctrl #(
    parameter int unsigned TIME_W      = 32,
    parameter int unsigned COUNT_W     = 16,
    parameter int unsigned QBYTE_W     = 24,
    parameter int unsigned TARGET_US   = 5000,
    parameter int unsigned INTERVAL_US = 100000,
    parameter int unsigned MTU_BYTES   = 1500
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pkt_valid,
    input  logic [TIME_W-1:0]  pkt_delay_us,
    input  logic [QBYTE_W-1:0] pkt_qbytes,
    input  logic [TIME_W-1:0]  now_us,
    output logic               verdict_valid,
    output logic               verdict_drop
);
    logic               dropping_q;
    logic [COUNT_W-1:0] count_q;
    logic [COUNT_W-1:0] kept_q;
    logic [TIME_W-1:0]  next_q;

    logic               drop_c;
    logic               dropping_c;
    logic [COUNT_W-1:0] count_c;
    logic [COUNT_W-1:0] kept_c;
    logic [TIME_W-1:0]  next_c;
    logic [COUNT_W-1:0] bump_c;
    logic [TIME_W-1:0]  spacing_c;

    codel_spacing_rom #(
        .TIME_W(TIME_W), .COUNT_W(COUNT_W), .INTERVAL_US(INTERVAL_US)
    ) u_rom (
        .count(bump_c), .spacing(spacing_c)
    );

    codel_decide #(
        .TIME_W(TIME_W), .COUNT_W(COUNT_W), .QBYTE_W(QBYTE_W),
        .TARGET_US(TARGET_US), .INTERVAL_US(INTERVAL_US), .MTU_BYTES(MTU_BYTES)
    ) u_decide (
        .delay_us(pkt_delay_us), .qbytes(pkt_qbytes), .now_us(now_us),
        .dropping(dropping_q), .count(count_q), .kept_count(kept_q),
        .next_time(next_q), .spacing(spacing_c), .count_bump(bump_c),
        .drop(drop_c), .dropping_nx(dropping_c), .count_nx(count_c),
        .kept_nx(kept_c), .next_nx(next_c)
    );

    // Commits the state for each strobed packet.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dropping_q <= 1'b0;
            count_q    <= '0;
            kept_q     <= '0;
            next_q     <= '0;
        end else if (pkt_valid) begin
            dropping_q <= dropping_c;
            count_q    <= count_c;
            kept_q     <= kept_c;
            next_q     <= next_c;
        end
    end

    // Registers the verdict one cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            verdict_valid <= 1'b0;
            verdict_drop  <= 1'b0;
        end else begin
            verdict_valid <= pkt_valid;
            verdict_drop  <= pkt_valid & drop_c;
        end
    end
endmodule

// File: rtl/codel_drop_ctrl_chk.sv
// Cycle-level properties of the drop controller, bound to its top.
// Assumes it can see the top's state registers.
module codel_drop_ctrl_chk #(
    parameter int unsigned TIME_W      = 32,
    parameter int unsigned COUNT_W     = 16,
    parameter int unsigned QBYTE_W     = 24,
    parameter int unsigned TARGET_US   = 5000,
    parameter int unsigned INTERVAL_US = 100000,
    parameter int unsigned MTU_BYTES   = 1500
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pkt_valid,
    input logic [TIME_W-1:0]  pkt_delay_us,
    input logic [QBYTE_W-1:0] pkt_qbytes,
    input logic [TIME_W-1:0]  now_us,
    input logic               verdict_valid,
    input logic               verdict_drop,
    input logic               dropping_q,
    input logic [COUNT_W-1:0] count_q,
    input logic [TIME_W-1:0]  next_q
);
    localparam logic [COUNT_W-1:0] CMAX = '1;

    logic below_target;
    logic violating;
    logic early;
    assign below_target = pkt_delay_us < TIME_W'(TARGET_US);
    assign violating    = !below_target && (pkt_qbytes >= QBYTE_W'(MTU_BYTES));
    assign early        = $signed(now_us - next_q) < 0;

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !verdict_valid && !verdict_drop); // R1
    AST_FWD_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && below_target |=> !verdict_drop && !dropping_q); // R2
    AST_ENTRY_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && violating && !dropping_q |=> !verdict_drop && dropping_q); // R3
    AST_NO_EARLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid && early |=> !verdict_drop); // R4
    AST_COUNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_drop |-> count_q == (($past(count_q) == CMAX) ? CMAX : $past(count_q) + 1'b1)); // R9
    AST_VERDICT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |=> verdict_valid); // R8
    AST_NO_STRAY_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |=> !verdict_valid && !verdict_drop); // R8
endmodule

bind codel_drop_ctrl codel_drop_ctrl_chk #(
    .TIME_W(TIME_W), .COUNT_W(COUNT_W), .QBYTE_W(QBYTE_W),
    .TARGET_US(TARGET_US), .INTERVAL_US(INTERVAL_US), .MTU_BYTES(MTU_BYTES)
) u_chk (.*);

// File: tb/codel_drop_ctrl_bench.sv
// Directed scenarios for the drop controller, one task for each.
module codel_drop_ctrl_bench;
    localparam int unsigned TW   = 32;
    localparam int unsigned CW   = 9;
    localparam int unsigned QW   = 24;
    localparam int unsigned IVL  = 100000;
    localparam logic [TW-1:0] HI_DLY = 32'd20000;
    localparam logic [QW-1:0] BIG_Q  = 24'd60000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pkt_valid = 1'b0;
    logic [TW-1:0] pkt_delay_us = '0;
    logic [QW-1:0] pkt_qbytes = '0;
    logic [TW-1:0] now_us = '0;
    logic          verdict_valid;
    logic          verdict_drop;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    codel_drop_ctrl #(
        .TIME_W(TW), .COUNT_W(CW), .QBYTE_W(QW),
        .TARGET_US(5000), .INTERVAL_US(IVL), .MTU_BYTES(1500)
    ) u_codel_drop_ctrl (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid),
        .pkt_delay_us(pkt_delay_us), .pkt_qbytes(pkt_qbytes), .now_us(now_us),
        .verdict_valid(verdict_valid), .verdict_drop(verdict_drop)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pkt_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One packet: drive at a falling edge, check the verdict one cycle later.
    task automatic send(input logic [TW-1:0] dly, input logic [QW-1:0] q,
                        input logic [TW-1:0] t, input logic exp, input string req);
        @(negedge clk);
        pkt_valid = 1'b1; pkt_delay_us = dly; pkt_qbytes = q; now_us = t;
        @(negedge clk);
        pkt_valid = 1'b0;
        check(verdict_valid, 1'b1, req, "valid");
        check(verdict_drop, exp, req, $sformatf("drop at t=%0d", t));
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(verdict_valid, 1'b0, "R1", "valid after reset");
        check(verdict_drop, 1'b0, "R1", "drop after reset");
        // Cleared state: first violation is an entry, never a discard.
        send(HI_DLY, BIG_Q, 32'd999999, 1'b0, "R1");
    endtask

    task automatic t_forward_rules();
        do_reset();
        send(32'd100, BIG_Q, 32'd1000, 1'b0, "R2");
        send(HI_DLY, 24'd1000, 32'd2000, 1'b0, "R2");
        send(HI_DLY, BIG_Q, 32'd3000, 1'b0, "R3");      // entry, next = 103000
        send(32'd4999, BIG_Q, 32'd103000, 1'b0, "R2");  // leaves dropping
        send(HI_DLY, BIG_Q, 32'd500000, 1'b0, "R2");    // entry again, no drop
    endtask

    task automatic t_drop_spacing();
        do_reset();
        send(HI_DLY, BIG_Q, 32'd1000000, 1'b0, "R3");
        send(HI_DLY, BIG_Q, 32'd1050000, 1'b0, "R4");
        send(HI_DLY, BIG_Q, 32'd1099999, 1'b0, "R4");
        send(HI_DLY, BIG_Q, 32'd1100000, 1'b1, "R4");   // count 2
        send(HI_DLY, BIG_Q, 32'd1170709, 1'b0, "R5");
        send(HI_DLY, BIG_Q, 32'd1170710, 1'b1, "R5");   // count 3
        send(HI_DLY, BIG_Q, 32'd1228445, 1'b1, "R5");   // count 4, next 1278445
    endtask

    task automatic t_restart();
        send(32'd10, BIG_Q, 32'd1280000, 1'b0, "R6");
        send(HI_DLY, BIG_Q, 32'd1300000, 1'b0, "R6");   // fast restart, count 3
        send(HI_DLY, BIG_Q, 32'd1400000, 1'b1, "R6");   // count 4
        send(HI_DLY, BIG_Q, 32'd1449999, 1'b0, "R6");
        send(HI_DLY, BIG_Q, 32'd1450000, 1'b1, "R6");   // count 5, next 1494721
        send(32'd10, BIG_Q, 32'd1460000, 1'b0, "R6");
        send(HI_DLY, BIG_Q, 32'd4000000, 1'b0, "R6");   // too late: count 1
        send(HI_DLY, BIG_Q, 32'd4100000, 1'b1, "R6");   // count 2
        send(HI_DLY, BIG_Q, 32'd4170709, 1'b0, "R6");
        send(HI_DLY, BIG_Q, 32'd4170710, 1'b1, "R6");
    endtask

    task automatic t_wrap();
        do_reset();
        send(HI_DLY, BIG_Q, 32'hFFFF3CAF, 1'b0, "R7");  // next wraps to 49999
        send(HI_DLY, BIG_Q, 32'hFFFFFFFF, 1'b0, "R7");
        send(HI_DLY, BIG_Q, 32'd49998, 1'b0, "R7");
        send(HI_DLY, BIG_Q, 32'd49999, 1'b1, "R7");
    endtask

    task automatic t_back_to_back();
        logic [TW-1:0] ts [4] = '{32'd5000000, 32'd5100000, 32'd5100000, 32'd5170710};
        logic          ex [4] = '{1'b0, 1'b1, 1'b0, 1'b1};
        do_reset();
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            pkt_valid = 1'b1; pkt_delay_us = HI_DLY; pkt_qbytes = BIG_Q; now_us = ts[i];
            @(negedge clk);
            check(verdict_valid, 1'b1, "R8", "back-to-back valid");
            check(verdict_drop, ex[i], "R8", $sformatf("back-to-back drop %0d", i));
        end
        pkt_valid = 1'b0;
        @(negedge clk);
        check(verdict_valid, 1'b0, "R8", "valid after strobes stop");
    endtask

    // Runs well past the table end and the count limit; spacing must hold.
    task automatic t_saturate();
        longint unsigned t;
        int unsigned     c;
        int unsigned     k;
        do_reset();
        t = 64'd10000000;
        send(HI_DLY, BIG_Q, TW'(t), 1'b0, "R9");
        t = t + IVL;
        c = 1;
        for (int i = 0; i < 530; i++) begin
            send(HI_DLY, BIG_Q, TW'(t - 1), 1'b0, (c >= 255) ? "R9" : "R5");
            send(HI_DLY, BIG_Q, TW'(t), 1'b1, (c >= 255) ? "R9" : "R5");
            if (c < 511) c = c + 1;
            k = (c > 255) ? 255 : c;
            t = t + longint'($floor(real'(IVL) / $sqrt(real'(k))));
        end
    endtask

    initial begin
        t_reset();
        t_forward_rules();
        t_drop_spacing();
        t_restart();
        t_wrap();
        t_back_to_back();
        t_saturate();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule